// File: doc/BRIEF.md
# Head-of-Line Probe Controller for a Multi-Plane Cell Switch Input Port

This block sits at one input port of a slotted cell switch. The switch fabric is a stack of K parallel self-routing planes that hold no buffers. Arriving cells wait in a small first-in first-out queue. The cell at the head of the queue leaves only after the fabric has confirmed that the path to its outlet is free.

Each slot begins with an external one-cycle pulse. After the pulse the controller follows a fixed timeline. At a fixed cycle it raises a one-cycle probe that carries the outlet of the head cell and the plane chosen for this slot. For a few cycles after the probe it watches for an acknowledgment from the fabric. If one arrives in that window, the head cell goes out on the same plane at a fixed data cycle and is removed from the queue. If none arrives, the cell stays at the head and is probed again in the next slot.

The plane is picked once per slot. In alternate mode the port always uses one fixed home plane. In random mode the plane comes from the low bits of a free-running shift register. A cell that finds the queue full is dropped and counted.

Top module: `ipc_hol_probe`

## Requirements
- R1: While reset is applied, and from reset release up to the first slot pulse, `probeValid` and `cellValid` stay low and `lossCount` is zero. The slot phase counter rests at its idle value, 2^ceil(log2(DATA_PH+2))-1, which is 7 by default. It counts up from there only after a slot pulse.
- R2: A cell is taken only in the cycle where `slotStart` is high and `arrValid` is high, so the queue is written at most once per slot. `arrValid` in any other cycle has no effect.
- R3: The phase is the number of cycles since the `slotStart` cycle minus one, so the cycle after the pulse is phase 0. In phase PROBE_PH (default 1) `probeValid` is high for exactly one cycle, and only if the queue holds a cell. `probeOutlet` then carries the outlet of the oldest cell still queued.
- R4: An acknowledgment counts when `ackIn` is high in a phase from PROBE_PH+1 to ACK_LAST (defaults 2 to 4) of a slot in which a probe was sent. After such an acknowledgment, `cellValid` is high for one cycle in phase DATA_PH (default 5). In that cycle `cellOutlet` and `cellPayload` carry the head cell, and the cell is then removed from the queue. Without an acknowledgment the head cell stays and is probed again in the next slot.
- R5: `cellPlane` in the data cycle equals `probePlane` of the probe in the same slot.
- R6: In random mode (`loadMode`=1 at the slot pulse), the plane is the low log2(K) bits of a 16-bit shift register. The register starts at 0xACE1 after reset. At each slot pulse it shifts left by one, and the new bit 0 is bit15 ^ bit13 ^ bit12 ^ bit10. The plane takes the value held before the shift. The register advances on every slot pulse, whatever the mode.
- R7: In alternate mode (`loadMode`=0 at the slot pulse), the plane is the parameter HOME_PLANE (default 2). The mode is sampled only on the slot pulse.
- R8: If a cell arrives while the queue holds DEPTH cells (default 4), the cell is dropped and `lossCount` rises by one, saturating at its maximum value. A cell leaving in that same cycle does not make room for it.
- R9: `ackIn` has no effect in the following cases: in the probe cycle, after ACK_LAST, or in a slot with no probe. It changes no output and moves no cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| slotStart | input | 1 | One-cycle pulse that opens a slot |
| loadMode | input | 1 | Plane choice, sampled at the slot pulse: 0 selects the fixed home plane, 1 selects a random plane |
| arrValid | input | 1 | A cell is offered (counted only with `slotStart`) |
| arrOutlet | input | OUT_W | Outlet requested by the offered cell |
| arrPayload | input | CELL_W | Payload of the offered cell |
| probeValid | output | 1 | Probe toward the fabric |
| probePlane | output | log2(PLANES) | Plane the probe uses |
| probeOutlet | output | OUT_W | Outlet of the head cell |
| ackIn | input | 1 | Acknowledgment from the fabric |
| cellValid | output | 1 | Head cell is sent in this cycle |
| cellPlane | output | log2(PLANES) | Plane the cell is sent on |
| cellOutlet | output | OUT_W | Outlet of the cell sent |
| cellPayload | output | CELL_W | Payload of the cell sent |
| lossCount | output | LOSS_W | Saturating count of cells dropped because the queue was full |

## Verification
The hardest state to reach from the ports is an acknowledgment at the exact edge of the window. An ack at the last valid phase must move a cell; an ack in the probe cycle, one phase after the window closes, or in a slot with no probe must not. The stimulus task places `ackIn` at a chosen phase relative to the slot pulse, so each of these edges gets a slot of its own. Retries are forced by withholding acks until the queue overflows. A pseudo-random soak then mixes modes, arrivals, stray off-slot arrivals and ack phases, while the reference model follows every cycle.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  // Strobes from the slot controller to the queue datapath.
  typedef struct packed {
    logic push;     // store the offered cell
    logic pop;      // retire the head cell
    logic dropInc;  // queue full at arrival: count a loss
  } qStrobe_t;
endpackage

// File: rtl/ipc_queue.sv
module ipc_queue
  import ipc_pkg::*;
#(
  parameter int CELL_W = 16,
  parameter int OUT_W  = 4,
  parameter int DEPTH  = 4,
  parameter int LOSS_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          strobe,
  input  logic [OUT_W-1:0]  wrOutlet,
  input  logic [CELL_W-1:0] wrPayload,
  output logic [OUT_W-1:0]  headOutlet,
  output logic [CELL_W-1:0] headPayload,
  output logic              empty,
  output logic              full,
  output logic [LOSS_W-1:0] lossCount
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [OUT_W-1:0]  outletMem  [DEPTH];
  logic [CELL_W-1:0] payloadMem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [CW-1:0]     level;

  // One register slot per entry, written when the write pointer selects it.
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (strobe.push && (wrPtr == AW'(e))) begin
        outletMem[e]  <= wrOutlet;
        payloadMem[e] <= wrPayload;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      level     <= '0;
      lossCount <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + AW'(1);
      if (strobe.pop)  rdPtr <= rdPtr + AW'(1);
      level <= level + CW'(strobe.push) - CW'(strobe.pop);
      if (strobe.dropInc && (lossCount != '1)) lossCount <= lossCount + LOSS_W'(1);
    end
  end

  assign headOutlet  = outletMem[rdPtr];
  assign headPayload = payloadMem[rdPtr];
  assign empty       = (level == '0);
  assign full        = (level == CW'(DEPTH));
endmodule

// File: rtl/ipc_plane_sel.sv
module ipc_plane_sel #(
  parameter int          PLANES     = 4,
  parameter int          HOME_PLANE = 2,
  parameter logic [15:0] SEED       = 16'hACE1,
  localparam int         PW         = $clog2(PLANES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          advance,
  input  logic          randomMode,
  output logic [PW-1:0] pick
);
  logic [15:0] lfsrQ;
  logic        feedback;

  assign feedback = lfsrQ[15] ^ lfsrQ[13] ^ lfsrQ[12] ^ lfsrQ[10];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lfsrQ <= SEED;
    else if (advance) lfsrQ <= {lfsrQ[14:0], feedback};
  end

  // K is a power of two, so the low bits are the register reduced modulo K.
  assign pick = randomMode ? lfsrQ[PW-1:0] : PW'(HOME_PLANE);
endmodule

// File: rtl/ipc_slot_ctrl.sv
module ipc_slot_ctrl
  import ipc_pkg::*;
#(
  parameter int PLANES   = 4,
  parameter int PROBE_PH = 1,
  parameter int ACK_LAST = 4,
  parameter int DATA_PH  = 5,
  localparam int PW      = $clog2(PLANES),
  localparam int PH_W    = $clog2(DATA_PH + 2)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          slotStart,
  input  logic          arrValid,
  input  logic          qEmpty,
  input  logic          qFull,
  input  logic          ackIn,
  input  logic [PW-1:0] planePick,
  output qStrobe_t      strobe,
  output logic          probeValid,
  output logic          cellValid,
  output logic [PW-1:0] planeQ,
  output logic          planeAdvance
);
  localparam logic [PH_W-1:0] PH_IDLE = '1;

  logic [PH_W-1:0] phaseQ;
  logic            probeSentQ;
  logic            ackSeenQ;
  logic            inAckWin;

  assign inAckWin   = (phaseQ > PH_W'(PROBE_PH)) && (phaseQ <= PH_W'(ACK_LAST));
  assign probeValid = (phaseQ == PH_W'(PROBE_PH)) && !qEmpty;
  assign cellValid  = (phaseQ == PH_W'(DATA_PH)) && ackSeenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ     <= PH_IDLE;
      probeSentQ <= 1'b0;
      ackSeenQ   <= 1'b0;
      planeQ     <= '0;
    end else if (slotStart) begin
      phaseQ     <= '0;
      probeSentQ <= 1'b0;
      ackSeenQ   <= 1'b0;
      planeQ     <= planePick;
    end else begin
      if (phaseQ != PH_IDLE) phaseQ <= phaseQ + PH_W'(1);
      if (probeValid) probeSentQ <= 1'b1;
      if (inAckWin && ackIn && probeSentQ) ackSeenQ <= 1'b1;
    end
  end

  always_comb begin
    strobe.push    = slotStart && arrValid && !qFull;
    strobe.dropInc = slotStart && arrValid && qFull;
    strobe.pop     = cellValid;
  end

  assign planeAdvance = slotStart;
endmodule

// File: rtl/ipc_hol_probe.sv
module ipc_hol_probe
  import ipc_pkg::*;
#(
  parameter int          CELL_W     = 16,
  parameter int          OUT_W      = 4,
  parameter int          DEPTH      = 4,
  parameter int          PLANES     = 4,
  parameter int          HOME_PLANE = 2,
  parameter logic [15:0] SEED       = 16'hACE1,
  parameter int          LOSS_W     = 8,
  parameter int          PROBE_PH   = 1,
  parameter int          ACK_LAST   = 4,
  parameter int          DATA_PH    = 5,
  localparam int         PW         = $clog2(PLANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotStart,
  input  logic              loadMode,
  input  logic              arrValid,
  input  logic [OUT_W-1:0]  arrOutlet,
  input  logic [CELL_W-1:0] arrPayload,
  output logic              probeValid,
  output logic [PW-1:0]     probePlane,
  output logic [OUT_W-1:0]  probeOutlet,
  input  logic              ackIn,
  output logic              cellValid,
  output logic [PW-1:0]     cellPlane,
  output logic [OUT_W-1:0]  cellOutlet,
  output logic [CELL_W-1:0] cellPayload,
  output logic [LOSS_W-1:0] lossCount
);
  qStrobe_t          strobe;
  logic              qEmpty, qFull, planeAdvance;
  logic [PW-1:0]     planePick, planeQ;
  logic [OUT_W-1:0]  headOutlet;
  logic [CELL_W-1:0] headPayload;

  ipc_plane_sel #(.PLANES(PLANES), .HOME_PLANE(HOME_PLANE), .SEED(SEED)) u_sel (
    .clk(clk), .rstN(rstN), .advance(planeAdvance), .randomMode(loadMode), .pick(planePick)
  );

  ipc_slot_ctrl #(.PLANES(PLANES), .PROBE_PH(PROBE_PH), .ACK_LAST(ACK_LAST),
                  .DATA_PH(DATA_PH)) u_ctrl (
    .clk(clk), .rstN(rstN), .slotStart(slotStart), .arrValid(arrValid),
    .qEmpty(qEmpty), .qFull(qFull), .ackIn(ackIn), .planePick(planePick),
    .strobe(strobe), .probeValid(probeValid), .cellValid(cellValid),
    .planeQ(planeQ), .planeAdvance(planeAdvance)
  );

  ipc_queue #(.CELL_W(CELL_W), .OUT_W(OUT_W), .DEPTH(DEPTH), .LOSS_W(LOSS_W)) u_queue (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrOutlet(arrOutlet), .wrPayload(arrPayload),
    .headOutlet(headOutlet), .headPayload(headPayload), .empty(qEmpty), .full(qFull),
    .lossCount(lossCount)
  );

  assign probePlane  = planeQ;
  assign probeOutlet = headOutlet;
  assign cellPlane   = planeQ;
  assign cellOutlet  = headOutlet;
  assign cellPayload = headPayload;
endmodule

// File: rtl/ipc_hol_probe_chk.sv
module ipc_hol_probe_chk #(
  parameter int  OUT_W      = 4,
  parameter int  PLANES     = 4,
  parameter int  HOME_PLANE = 2,
  parameter int  LOSS_W     = 8,
  localparam int PW         = $clog2(PLANES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              slotStart,
  input logic              loadMode,
  input logic              arrValid,
  input logic              ackIn,
  input logic              probeValid,
  input logic [PW-1:0]     probePlane,
  input logic [OUT_W-1:0]  probeOutlet,
  input logic              cellValid,
  input logic [PW-1:0]     cellPlane,
  input logic [OUT_W-1:0]  cellOutlet,
  input logic [LOSS_W-1:0] lossCount
);
  logic [PW-1:0]    lastPlane;
  logic [OUT_W-1:0] lastOutlet;
  logic             modeAtSlot, probeSeen, gotAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastPlane  <= '0;
      lastOutlet <= '0;
      modeAtSlot <= 1'b0;
      probeSeen  <= 1'b0;
      gotAck     <= 1'b0;
    end else if (slotStart) begin
      modeAtSlot <= loadMode;
      probeSeen  <= 1'b0;
      gotAck     <= 1'b0;
    end else if (probeValid) begin
      lastPlane  <= probePlane;
      lastOutlet <= probeOutlet;
      probeSeen  <= 1'b1;
      gotAck     <= 1'b0;
    end else if (ackIn && probeSeen) begin
      gotAck <= 1'b1;
    end
  end

  // R3: one probe per slot, never two cycles in a row
  p_single_probe_r3: assert property (@(posedge clk) disable iff (!rstN)
    probeValid |=> !probeValid);

  // R4: no cell leaves without an ack after this slot's probe
  p_ack_before_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    cellValid |-> gotAck);

  // R4: the data cycle lasts one cycle
  p_single_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    cellValid |=> !cellValid);

  // R5: cell follows the path and outlet of the probe
  p_same_path_r5: assert property (@(posedge clk) disable iff (!rstN)
    cellValid |-> (cellPlane == lastPlane) && (cellOutlet == lastOutlet));

  // R7: alternate mode keeps the home plane
  p_home_plane_r7: assert property (@(posedge clk) disable iff (!rstN)
    (probeValid && !modeAtSlot) |-> (probePlane == PW'(HOME_PLANE)));

  // R8: the loss count only steps by one
  p_loss_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lossCount != $past(lossCount)) |-> (lossCount == $past(lossCount) + LOSS_W'(1)));

  // R8: a loss needs an arrival at a slot pulse
  p_loss_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lossCount != $past(lossCount)) |-> $past(slotStart && arrValid));
endmodule

bind ipc_hol_probe ipc_hol_probe_chk #(
  .OUT_W(OUT_W), .PLANES(PLANES), .HOME_PLANE(HOME_PLANE), .LOSS_W(LOSS_W)
) u_chk (
  .clk(clk), .rstN(rstN), .slotStart(slotStart), .loadMode(loadMode), .arrValid(arrValid),
  .ackIn(ackIn), .probeValid(probeValid), .probePlane(probePlane), .probeOutlet(probeOutlet),
  .cellValid(cellValid), .cellPlane(cellPlane), .cellOutlet(cellOutlet), .lossCount(lossCount)
);

// File: tb/sim_ipc_hol_probe.sv
module sim_ipc_hol_probe;
  localparam int CLK_PERIOD = 10;
  localparam int CELL_W   = 16;
  localparam int OUT_W    = 4;
  localparam int DEPTH    = 4;
  localparam int PLANES   = 4;
  localparam int HOME     = 2;
  localparam int LOSS_W   = 8;
  localparam int PROBE_PH = 1;
  localparam int ACK_LAST = 4;
  localparam int DATA_PH  = 5;
  localparam int PH_IDLE  = 7;
  localparam int SLOT_LEN = 8;
  localparam int PW       = $clog2(PLANES);

  logic clk = 1'b0, rstN = 1'b0, slotStart = 1'b0, loadMode = 1'b0;
  logic arrValid = 1'b0, ackIn = 1'b0;
  logic [OUT_W-1:0]  arrOutlet = '0;
  logic [CELL_W-1:0] arrPayload = '0;
  logic              probeValid, cellValid;
  logic [PW-1:0]     probePlane, cellPlane;
  logic [OUT_W-1:0]  probeOutlet, cellOutlet;
  logic [CELL_W-1:0] cellPayload;
  logic [LOSS_W-1:0] lossCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_hol_probe u0 (
    .clk(clk), .rstN(rstN), .slotStart(slotStart), .loadMode(loadMode),
    .arrValid(arrValid), .arrOutlet(arrOutlet), .arrPayload(arrPayload),
    .probeValid(probeValid), .probePlane(probePlane), .probeOutlet(probeOutlet),
    .ackIn(ackIn), .cellValid(cellValid), .cellPlane(cellPlane),
    .cellOutlet(cellOutlet), .cellPayload(cellPayload), .lossCount(lossCount)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: behavioural, queues and integers
  int                mPhase = PH_IDLE;
  bit                mProbeSent, mAckSeen, mMode;
  logic [PW-1:0]     mPlane;
  logic [15:0]       mLfsr = 16'hACE1;
  logic [LOSS_W-1:0] mLoss = '0;
  logic [OUT_W-1:0]  qOut [$];
  logic [CELL_W-1:0] qPay [$];
  int                oldPhase;
  bit                uProbe, uCell, uFull;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = PH_IDLE; mProbeSent = 0; mAckSeen = 0; mMode = 0; mPlane = '0;
      mLfsr = 16'hACE1; mLoss = '0; qOut.delete(); qPay.delete();
    end else begin
      oldPhase = mPhase;
      uCell  = (oldPhase == DATA_PH) && mAckSeen;
      uProbe = (oldPhase == PROBE_PH) && (qOut.size() > 0);
      uFull  = (qOut.size() == DEPTH);
      if (uCell) begin void'(qOut.pop_front()); void'(qPay.pop_front()); end
      if (slotStart) begin
        if (arrValid) begin
          if (uFull) begin
            if (mLoss != '1) mLoss = mLoss + LOSS_W'(1);
          end else begin
            qOut.push_back(arrOutlet); qPay.push_back(arrPayload);
          end
        end
        mMode  = loadMode;
        mPlane = loadMode ? mLfsr[PW-1:0] : PW'(HOME);
        mLfsr  = {mLfsr[14:0], mLfsr[15] ^ mLfsr[13] ^ mLfsr[12] ^ mLfsr[10]};
        mPhase = 0; mProbeSent = 0; mAckSeen = 0;
      end else begin
        if (mPhase < PH_IDLE) mPhase++;
        if (ackIn && mProbeSent && oldPhase > PROBE_PH && oldPhase <= ACK_LAST) mAckSeen = 1;
        if (uProbe) mProbeSent = 1;
      end
    end
  end

  bit nProbe, nCell;
  always @(negedge clk) begin
    if (rstN && !done) begin
      nProbe = (mPhase == PROBE_PH) && (qOut.size() > 0);
      nCell  = (mPhase == DATA_PH) && mAckSeen;
      check(probeValid == nProbe, "R2 R3 probe presence", longint'(probeValid), longint'(nProbe));
      if (nProbe) begin
        check(probeOutlet == qOut[0], "R3 probe outlet", longint'(probeOutlet), longint'(qOut[0]));
        check(probePlane == mPlane, mMode ? "R6 random plane" : "R7 home plane",
              longint'(probePlane), longint'(mPlane));
      end
      check(cellValid == nCell, "R4 R9 data strobe", longint'(cellValid), longint'(nCell));
      if (nCell) begin
        check(cellOutlet == qOut[0], "R4 cell outlet", longint'(cellOutlet), longint'(qOut[0]));
        check(cellPayload == qPay[0], "R4 cell payload", longint'(cellPayload), longint'(qPay[0]));
        check(cellPlane == mPlane, "R5 cell plane", longint'(cellPlane), longint'(mPlane));
      end
      check(lossCount == mLoss, "R8 loss count", longint'(lossCount), longint'(mLoss));
    end
  end

  // One slot; ackPh is the phase in which ackIn is raised (-1: none)
  task automatic runSlot(input bit mode, input bit arr, input logic [OUT_W-1:0] o,
                         input logic [CELL_W-1:0] p, input int ackPh, input bit stray);
    for (int c = 0; c < SLOT_LEN; c++) begin
      @(negedge clk); #1;
      slotStart  = (c == 0);
      loadMode   = mode;
      arrValid   = (c == 0) ? arr : (stray && c == 3);
      arrOutlet  = o;
      arrPayload = (c == 0) ? p : ~p;
      ackIn      = (ackPh >= 0) && (c == ackPh + 1);
    end
    @(negedge clk); #1;
    slotStart = 0; arrValid = 0; ackIn = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  int seed = 7;
  initial begin
    repeat (3) @(negedge clk);
    check(!probeValid && !cellValid, "R1 outputs idle in reset", longint'({probeValid, cellValid}), 0);
    check(lossCount == 0, "R1 loss zero in reset", longint'(lossCount), 0);
    #1 rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(!probeValid && !cellValid, "R1 idle before first slot", longint'({probeValid, cellValid}), 0);

    runSlot(0, 1, 4'd3, 16'h1111, 2, 0);   // R4 immediate departure
    runSlot(0, 1, 4'd5, 16'h2222, -1, 0);  // R4 retry
    runSlot(0, 1, 4'd6, 16'h3333, 4, 0);   // R4 ack at last window phase
    runSlot(0, 0, 4'd0, 16'h0, 5, 0);      // R9 ack after window
    runSlot(0, 0, 4'd0, 16'h0, 1, 0);      // R9 ack in probe cycle
    runSlot(0, 0, 4'd0, 16'h0, 3, 0);      // drain
    runSlot(0, 0, 4'd0, 16'h0, 2, 0);      // R9 ack with no probe
    runSlot(0, 0, 4'd9, 16'h9999, -1, 1);  // R2 stray arrival only
    @(negedge clk);
    runSlot(0, 0, 4'd0, 16'h0, -1, 0);
    for (int i = 0; i < 6; i++) runSlot(0, 1, OUT_W'(i + 1), CELL_W'(16'hA000 + i), -1, 0);
    check(lossCount == 2, "R8 drops at full queue", longint'(lossCount), 2);
    for (int i = 0; i < 6; i++) runSlot(1, i[0], OUT_W'(i + 8), CELL_W'(16'hB000 + i), 2, 0);
    for (int i = 0; i < 60; i++) begin
      int ph;
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      ph = (seed >> 8) % 7 - 1;
      runSlot(seed[20], seed[17] | seed[18], OUT_W'(seed >> 3), CELL_W'(seed >> 5), ph, seed[21]);
    end
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule